// File: doc/BRIEF.md
# Serial Flash Command Frame Shifter

This block sends one short command frame to a serial NOR flash over a single-bit SPI link (mode 0) and keeps the reply for software. Software stages an opcode and up to five further bytes in a bank of six transmit byte registers, sets the frame length in bits, and writes a command code into the command register. The engine then holds chip select low for exactly the programmed number of bits and shifts the staged bytes out MSB first, starting at the highest-index transmit register. The flash's answer is gathered bit by bit and, when the frame ends, copied into a bank of seven capture byte registers. The last byte received lands in the lowest capture index.

Two fixed-form commands sit beside the generic frame. A status read sends the flash's status-read opcode and keeps the one byte that comes back in a separate status register. A status write sends the byte in the top transmit register as an 8-bit frame, whatever the length register holds. Completion is signalled by the command register reading back as zero: the code written stays visible while the frame runs and clears itself at the end. The SPI clock is the system clock divided by a fixed parameter.

Top module: `sfc_cmd_shifter`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` is 0, and every register reads 0: command at address 0, length at 1, status at 2, transmit bytes at 8..13, capture bytes at 16..22.
- R2: Writing code 0x04 to address 0 while idle, with a length register value N from 1 to 56, holds `spi_cs_n` low for exactly N rising edges of `spi_sck`. Each bit lasts 2*DIV clocks, and `spi_sck` is low whenever `spi_cs_n` is high.
- R3: A generic frame sends transmit byte 5 (address 13) first and byte 0 (address 8) last, each MSB first, followed by zeros for bits 49..56. `spi_mosi` changes only while `spi_sck` is low.
- R4: `spi_miso` is sampled on each rising `spi_sck` edge. At the end of a generic frame of N bits, the received bits, right-aligned with the last one in bit 0 of capture byte 0 (address 16), fill capture bytes 0..6 upward. Bytes beyond the received bits read 0.
- R5: While a frame runs, address 0 reads back the code that started it (0x04, 0x02 or 0x20). The cycle after the last bit it reads 0.
- R6: Code 0x02 sends a 16-bit frame: opcode 0x05 followed by eight zero bits. The byte received in the last eight bits goes into the status register at address 2, and the capture bytes are not changed.
- R7: Code 0x20 sends an 8-bit frame that carries transmit byte 5, regardless of the length register.
- R8: Code 0x04 with a length of 0 or above 56, and any code other than 0x04, 0x02 or 0x20, are ignored: `spi_cs_n` stays high and address 0 keeps reading 0.
- R9: A write to address 0 during a frame is ignored. The running frame keeps its length and address 0 keeps its code.
- R10: Capture bytes keep their values during any frame and change only when a generic frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
On every cycle the assertions check the framing rules. The serial clock stays low outside a frame. The data line holds through each high phase. No frame has more than 56 rising edges. The command readback is non-zero exactly while chip select is low, and a start is only accepted while idle. The bench's scenarios are needed to show that the bit stream and the capture and status bytes carry the right values in the right order. They also show that the bit count matches the programmed length for a range of lengths, and that rejected starts leave the link quiet.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int TXB       = 6;
  localparam int CAPB      = 7;
  localparam int FRAME_MAX = CAPB * 8;
  localparam int WORD_W    = FRAME_MAX;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);
  localparam int ADDR_W    = 5;

  localparam logic [7:0] CODE_GENERIC = 8'h04;
  localparam logic [7:0] CODE_STAT_RD = 8'h02;
  localparam logic [7:0] CODE_STAT_WR = 8'h20;
  localparam logic [7:0] STAT_RD_OPCODE = 8'h05;

  localparam int A_CMD = 0;
  localparam int A_LEN = 1;
  localparam int A_STAT = 2;
  localparam int A_TX  = 8;
  localparam int A_CAP = 16;

  // Number of bits a start code produces; zero means the start is rejected.
  function automatic logic [LEN_W-1:0] frame_bits(input logic [7:0] code,
                                                  input logic [7:0] len);
    logic [LEN_W-1:0] n;
    n = '0;
    case (code)
      CODE_GENERIC: if (len != 8'd0 && int'(len) <= FRAME_MAX) n = len[LEN_W-1:0];
      CODE_STAT_RD: n = LEN_W'(16);
      CODE_STAT_WR: n = LEN_W'(8);
      default:      n = '0;
    endcase
    return n;
  endfunction

  // Outgoing word, sent from bit WORD_W-1 downward.
  function automatic logic [WORD_W-1:0] frame_word(input logic [7:0] code,
                                                   input logic [TXB*8-1:0] txcat);
    logic [WORD_W-1:0] w;
    w = '0;
    case (code)
      CODE_GENERIC: w = {txcat, {(WORD_W-TXB*8){1'b0}}};
      CODE_STAT_RD: w = {STAT_RD_OPCODE, {(WORD_W-8){1'b0}}};
      CODE_STAT_WR: w = {txcat[TXB*8-1 -: 8], {(WORD_W-8){1'b0}}};
      default:      w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/sfc_bit_engine.sv
module sfc_bit_engine
  import sfc_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [LEN_W-1:0]  launch_bits,
  input  logic [WORD_W-1:0] launch_word,
  input  logic              miso,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic              running;
  logic              phase_hi;
  logic [DW-1:0]     div_cnt;
  logic [LEN_W-1:0]  bits_done;
  logic [LEN_W-1:0]  nbits;
  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-1:0] rx_sh;
  logic              div_end;
  logic              last_bit;

  assign div_end  = (div_cnt == DW'(DIV - 1));
  assign last_bit = (bits_done == nbits - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      phase_hi  <= 1'b0;
      div_cnt   <= '0;
      bits_done <= '0;
      nbits     <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
    end else if (!running) begin
      if (launch) begin
        running   <= 1'b1;
        phase_hi  <= 1'b0;
        div_cnt   <= '0;
        bits_done <= '0;
        nbits     <= launch_bits;
        tx_sh     <= launch_word;
        rx_sh     <= '0;
      end
    end else if (div_end) begin
      div_cnt <= '0;
      if (!phase_hi) begin
        phase_hi <= 1'b1;
        rx_sh    <= {rx_sh[WORD_W-2:0], miso};
      end else begin
        phase_hi  <= 1'b0;
        bits_done <= bits_done + LEN_W'(1);
        tx_sh     <= {tx_sh[WORD_W-2:0], 1'b0};
        if (last_bit) running <= 1'b0;
      end
    end else begin
      div_cnt <= div_cnt + DW'(1);
    end
  end

  assign sck     = running & phase_hi;
  assign cs_n    = ~running;
  assign mosi    = running & tx_sh[WORD_W-1];
  assign busy    = running;
  assign done    = running & phase_hi & div_end & last_bit;
  assign rx_word = rx_sh;
endmodule

// File: rtl/sfc_reg_bank.sv
module sfc_reg_bank
  import sfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              eng_busy,
  input  logic              frame_done,
  input  logic [WORD_W-1:0] rx_word,
  output logic              start_accept,
  output logic [LEN_W-1:0]  launch_bits,
  output logic [WORD_W-1:0] launch_word,
  output logic [7:0]        active_code
);
  logic [7:0]        len_q;
  logic [7:0]        stat_q;
  logic [7:0]        active_q;
  logic [TXB*8-1:0]  txcat;
  logic [CAPB*8-1:0] capcat;
  logic              cmd_wr;

  assign cmd_wr       = bus_wr && (bus_addr == ADDR_W'(A_CMD));
  assign launch_bits  = frame_bits(bus_wdata, len_q);
  assign launch_word  = frame_word(bus_wdata, txcat);
  assign start_accept = cmd_wr && !eng_busy && (launch_bits != '0);
  assign active_code  = active_q;

  for (genvar g = 0; g < TXB; g++) begin : g_tx
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (bus_wr && bus_addr == ADDR_W'(A_TX + g)) q <= bus_wdata;
    end
    assign txcat[g*8 +: 8] = q;
  end

  for (genvar k = 0; k < CAPB; k++) begin : g_cap
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (frame_done && active_q == CODE_GENERIC) q <= rx_word[k*8 +: 8];
    end
    assign capcat[k*8 +: 8] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q    <= '0;
      stat_q   <= '0;
      active_q <= '0;
    end else begin
      if (bus_wr && bus_addr == ADDR_W'(A_LEN)) len_q <= bus_wdata;
      if (start_accept) active_q <= bus_wdata;
      else if (frame_done) begin
        active_q <= '0;
        if (active_q == CODE_STAT_RD) stat_q <= rx_word[7:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CMD))  bus_rdata = active_q;
    if (bus_addr == ADDR_W'(A_LEN))  bus_rdata = len_q;
    if (bus_addr == ADDR_W'(A_STAT)) bus_rdata = stat_q;
    for (int i = 0; i < TXB; i++)
      if (bus_addr == ADDR_W'(A_TX + i)) bus_rdata = txcat[i*8 +: 8];
    for (int k = 0; k < CAPB; k++)
      if (bus_addr == ADDR_W'(A_CAP + k)) bus_rdata = capcat[k*8 +: 8];
  end
endmodule

// File: rtl/sfc_cmd_shifter.sv
module sfc_cmd_shifter
  import sfc_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic              start_accept;
  logic              frame_done;
  logic              eng_busy;
  logic [LEN_W-1:0]  launch_bits;
  logic [WORD_W-1:0] launch_word;
  logic [WORD_W-1:0] rx_word;
  logic [7:0]        active_code;

  sfc_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .frame_done(frame_done), .rx_word(rx_word),
    .start_accept(start_accept), .launch_bits(launch_bits), .launch_word(launch_word),
    .active_code(active_code)
  );

  sfc_bit_engine #(.DIV(DIV)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .launch(start_accept), .launch_bits(launch_bits), .launch_word(launch_word),
    .miso(spi_miso), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .busy(eng_busy), .done(frame_done), .rx_word(rx_word)
  );
endmodule

// File: rtl/sfc_cmd_checker.sv
module sfc_cmd_checker
  import sfc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       cs_n,
  input logic       mosi,
  input logic       accept,
  input logic       done,
  input logic [7:0] active
);
  logic       sck_d;
  logic [7:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sck_d <= sck;
      if (cs_n) rise_cnt <= '0;
      else if (sck && !sck_d) rise_cnt <= rise_cnt + 8'd1;
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck); // R2
  AST_RISES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) int'(rise_cnt) <= FRAME_MAX); // R2
  AST_MOSI_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (sck && sck_d) |-> $stable(mosi)); // R3
  AST_CMD_TRACKS_CS: assert property (@(posedge clk) disable iff (!rst_n) (active != 8'h00) == !cs_n); // R5
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) done |=> (cs_n && active == 8'h00)); // R5
  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) accept |-> cs_n); // R9
  AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (!rst_n) accept |=> (!cs_n && !sck)); // R2
endmodule

bind sfc_cmd_shifter sfc_cmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
  .accept(start_accept), .done(frame_done), .active(active_code)
);

// File: tb/test_sfc_cmd_shifter.sv
`timescale 1ns/1ps
module test_sfc_cmd_shifter;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       spi_sck, spi_cs_n, spi_mosi;
  logic       spi_miso = 1'b0;

  always #10 clk = ~clk;

  sfc_cmd_shifter #(.DIV(HALF)) i_sfc_cmd_shifter (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_checks = 0, n_err = 0;
  int cyc_checks = 0, cyc_err = 0;
  bit wd_fired = 0;

  // Flash-side model and per-cycle chip-select reference.
  logic [55:0] resp_word = '0;
  logic [55:0] got = '0;
  int  rises = 0;
  logic prev_sck = 0, prev_cs = 1;
  int  ref_left = 0;
  int  mlen = 0;
  logic sv_wr = 0;
  logic [4:0] sv_addr = '0;
  logic [7:0] sv_data = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ref_left = 0; mlen = 0; sv_wr = 0;
    end else begin
      if (ref_left > 0) ref_left--;
      else if (sv_wr && sv_addr == 5'd0) begin
        if (sv_data == 8'h04 && mlen >= 1 && mlen <= 56) ref_left = mlen * 2 * HALF;
        else if (sv_data == 8'h02) ref_left = 16 * 2 * HALF;
        else if (sv_data == 8'h20) ref_left = 8 * 2 * HALF;
      end
      if (sv_wr && sv_addr == 5'd1) mlen = int'(sv_data);
      cyc_checks++;
      if (spi_cs_n !== (ref_left == 0)) begin
        cyc_err++;
        $display("FAIL R2 cycle cs_n act=%b exp=%b at %0t", spi_cs_n, (ref_left == 0), $time);
      end
    end
    sv_wr = bus_wr; sv_addr = bus_addr; sv_data = bus_wdata;
    if (!spi_cs_n && prev_cs) begin rises = 0; got = '0; end
    if (!spi_cs_n) begin
      if (spi_sck && !prev_sck) begin got = {got[54:0], spi_mosi}; rises++; end
      if (!spi_sck && rises < 56) spi_miso = resp_word[55 - rises];
    end
    prev_sck = spi_sck; prev_cs = spi_cs_n;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(posedge clk); #5;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #5;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(posedge clk); #5;
    bus_addr = a; #3;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    v = 8'hFF;
    while (v != 8'h00) rd(5'd0, v);
  endtask

  function automatic logic [55:0] take(input logic [55:0] w, input int n);
    logic [55:0] m;
    m = (n >= 56) ? {56{1'b1}} : ((56'd1 << n) - 56'd1);
    return (w >> (56 - n)) & m;
  endfunction

  logic [7:0] txb [6];
  logic [7:0] capx [7];

  task automatic load_tx();
    for (int i = 0; i < 6; i++) wr(5'(8 + i), txb[i]);
  endtask

  task automatic generic(input int n, input logic [55:0] resp, input string req);
    logic [7:0] v;
    logic [55:0] fw, rx;
    resp_word = resp;
    wr(5'd1, 8'(n));
    wr(5'd0, 8'h04);
    rd(5'd0, v);
    chk("R5 code readback while running", v, 8'h04);
    wait_idle();
    fw = {txb[5], txb[4], txb[3], txb[2], txb[1], txb[0], 8'h00};
    chk({req, " R2 rising edges"}, rises, n);
    chk({req, " R3 mosi stream"}, got, take(fw, n));
    rx = take(resp, n);
    for (int k = 0; k < 7; k++) begin
      rd(5'(16 + k), v);
      capx[k] = rx[k*8 +: 8];
      chk({req, " R4 capture byte"}, v, capx[k]);
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(posedge clk);
    // R1 reset state
    chk("R1 cs_n idle", spi_cs_n, 1'b1);
    chk("R1 sck idle", spi_sck, 1'b0);
    rd(5'd0, v); chk("R1 cmd", v, 0);
    rd(5'd2, v); chk("R1 status", v, 0);
    rd(5'd16, v); chk("R1 capture 0", v, 0);
    rd(5'd13, v); chk("R1 tx 5", v, 0);

    // opcode plus 3 reply bytes
    txb = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h9F};
    load_tx();
    generic(32, 56'hC3_5A_81_7E_11_22_33, "id32");

    // full 56-bit frame with every transmit byte set
    txb = '{8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'hA1};
    load_tx();
    generic(56, 56'hF0_E1_D2_C3_B4_A5_96, "max56");

    // partial-byte frame
    txb = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hB8};
    load_tx();
    generic(5, 56'h9F_00_00_00_00_00_00, "bits5");

    // R6 status read
    resp_word = 56'h00_D7_00_00_00_00_00;
    wr(5'd0, 8'h02);
    rd(5'd0, v); chk("R5 status-read code readback", v, 8'h02);
    wait_idle();
    chk("R6 status read edges", rises, 16);
    chk("R6 status read opcode", got, 56'h0500);
    rd(5'd2, v); chk("R6 status byte", v, 8'hD7);
    rd(5'd16, v); chk("R10 capture 0 kept after status read", v, capx[0]);
    rd(5'd17, v); chk("R10 capture 1 kept after status read", v, capx[1]);

    // R7 status write ignores the length register
    txb[5] = 8'hA5; wr(5'd13, 8'hA5);
    wr(5'd1, 8'd40);
    wr(5'd0, 8'h20);
    wait_idle();
    chk("R7 status write edges", rises, 8);
    chk("R7 status write byte", got, 56'hA5);

    // R8 rejected starts
    wr(5'd1, 8'd0); wr(5'd0, 8'h04);
    rd(5'd0, v); chk("R8 length 0 rejected", v, 0);
    chk("R8 length 0 cs idle", spi_cs_n, 1'b1);
    wr(5'd1, 8'd57); wr(5'd0, 8'h04);
    rd(5'd0, v); chk("R8 length 57 rejected", v, 0);
    wr(5'd1, 8'd16); wr(5'd0, 8'h08);
    rd(5'd0, v); chk("R8 unknown code rejected", v, 0);
    chk("R8 unknown code cs idle", spi_cs_n, 1'b1);

    // R9 / R10 write while busy
    txb = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h4B};
    load_tx();
    resp_word = 56'h12_34_00_00_00_00_00;
    wr(5'd1, 8'd16);
    wr(5'd0, 8'h04);
    wr(5'd0, 8'h02);
    rd(5'd0, v); chk("R9 code kept after busy write", v, 8'h04);
    rd(5'd16, v); chk("R10 capture 0 held mid-frame", v, capx[0]);
    wait_idle();
    chk("R9 length kept", rises, 16);
    chk("R9 stream kept", got, 56'h4B3C);
    rd(5'd16, v); chk("R4 capture after busy test", v, 8'h34);
    rd(5'd17, v); chk("R4 capture 1 after busy test", v, 8'h12);
    rd(5'd2, v); chk("R9 status untouched by ignored read", v, 8'hD7);

    repeat (10) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_err + cyc_err, n_checks + cyc_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    wd_fired = 1;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", n_err + cyc_err + 1, n_checks + cyc_checks + 1);
    $finish;
  end
endmodule